// File: doc/BRIEF.md
# Half-Duplex Transceive Sequencer

This block is the control state machine of a half-duplex reader front end. One exchange runs as transmit first, then receive. A start command arms the machine. A send trigger opens a guarded pre-transmit phase. The transmitter then runs until it reports completion. A guarded pre-receive phase follows. The receiver is then enabled, first to wait for incoming data and then to collect it. When the receiver reports completion, the machine returns to idle and raises a single-cycle completion pulse.

Each guarded phase holds for a programmable minimum number of clock cycles. The minimum for the transmit side and the minimum for the receive side come from separate inputs. When field waiting is enabled, each guarded phase also holds until an external field-present flag is high. The datapaths appear only as handshake flags. The current state is exposed as a fixed 3-bit code that software can read.

Top module: `trx_sequencer`

## Requirements
- R1: After reset, state_o is 000, tx_en_o and rx_en_o are low, and done_o is low.
- R2: The state codes are fixed as follows: 000 idle, 001 armed (waiting for send), 010 transmit guard, 011 transmitting, 100 receive guard, 101 waiting for receive data, 110 receiving. Code 111 never appears on state_o.
- R3: In 000, start_i moves the state to 001 on the next clock. In 001, the state holds until send_i is high, and the next clock then moves it to 010.
- R4: In a guard phase (010 or 100) with wait_field_en_i high, the state does not advance while field_i is low. With wait_field_en_i low, field_i has no effect.
- R5: Counting from its entry cycle, state 010 lasts at least max(N,1) cycles, where N is tx_wait_i. It leaves after exactly that many cycles when the field condition is met. N=0 means no minimum.
- R6: In 011, tx_done_i moves the state to 100 on the next clock.
- R7: State 100 obeys the same rule as R5, but uses rx_wait_i as its minimum, independently of tx_wait_i.
- R8: In 101, rx_detect_i moves the state to 110. In 110, rx_done_i moves the state to 000, and done_o is high for exactly the first cycle in 000.
- R9: tx_en_o is high exactly in 011. rx_en_o is high exactly in 101 and 110.
- R10: abort_i forces the state to 000 on the next clock from any state, takes priority over every other input, and produces no done_o pulse.
- R11: A handshake flag that does not belong to the current state (for example tx_done_i in 010, or rx_done_i in 101) has no effect on the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| abort_i | input | 1 | Synchronous abort to idle |
| start_i | input | 1 | Arm an exchange |
| send_i | input | 1 | Send trigger |
| field_i | input | 1 | External field present |
| wait_field_en_i | input | 1 | Make guard phases wait for the field |
| tx_wait_i | input | 8 | Minimum cycles in the transmit guard |
| rx_wait_i | input | 8 | Minimum cycles in the receive guard |
| tx_done_i | input | 1 | Transmitter finished |
| rx_detect_i | input | 1 | Receive data detected |
| rx_done_i | input | 1 | Receiver finished |
| state_o | output | 3 | Readable state code |
| tx_en_o | output | 1 | Transmitter enable |
| rx_en_o | output | 1 | Receiver enable |
| done_o | output | 1 | One-cycle exchange-complete pulse |

## Verification
The bench measures how long each guard phase lasts for minimums of 0, 1 and larger values. An off-by-one counter would show up as one cycle too many or too few, and a design that took 0 literally would try to skip the state. It keeps the field flag low while field waiting is on, and a gate on the wrong phase or of the wrong polarity would let the transmitter start early. It sends flags that belong to other states and aborts in the middle of an exchange. A design that decodes flags outside their own state, or that lets a normal transition win over abort, would leave idle or pulse done_o. A long random run against a behavioural model catches a phase that uses the wrong wait value or a completion pulse that lasts longer than one cycle.

// File: rtl/trx_seq_pkg.sv
package trx_seq_pkg;
  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE     = 3'b000,
    ST_ARM      = 3'b001,
    ST_TX_GUARD = 3'b010,
    ST_TX       = 3'b011,
    ST_RX_GUARD = 3'b100,
    ST_RX_WAIT  = 3'b101,
    ST_RX       = 3'b110
  } seq_state_e;

  localparam int N_GUARDS = 2;
  localparam int G_TX = 0;
  localparam int G_RX = 1;
endpackage

// File: rtl/trx_min_wait.sv
module trx_min_wait #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [CW-1:0] limit_i,
  output logic          elapsed_o
);
  localparam int EW = CW + 1;
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic [CW-1:0] cnt_q;

  // cnt_q = cycles already spent in the phase; saturates
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i)           cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign elapsed_o = ({1'b0, cnt_q} + EW'(1)) >= {1'b0, limit_i};

  // R5/R7: once elapsed with a steady limit, stays elapsed while running
  a_r5_elapsed_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && elapsed_o) |=> (!run_i || elapsed_o || (limit_i != $past(limit_i))));
endmodule

// File: rtl/trx_seq_fsm.sv
module trx_seq_fsm
  import trx_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       abort_i,
  input  logic       start_i,
  input  logic       send_i,
  input  logic       field_ok_i,
  input  logic       tx_elapsed_i,
  input  logic       rx_elapsed_i,
  input  logic       tx_done_i,
  input  logic       rx_detect_i,
  input  logic       rx_done_i,
  output seq_state_e state_o,
  output logic       done_o
);
  seq_state_e state_q, state_d;
  logic       done_q, done_d;

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    if (abort_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:     if (start_i) state_d = ST_ARM;
        ST_ARM:      if (send_i) state_d = ST_TX_GUARD;
        ST_TX_GUARD: if (tx_elapsed_i && field_ok_i) state_d = ST_TX;
        ST_TX:       if (tx_done_i) state_d = ST_RX_GUARD;
        ST_RX_GUARD: if (rx_elapsed_i && field_ok_i) state_d = ST_RX_WAIT;
        ST_RX_WAIT:  if (rx_detect_i) state_d = ST_RX;
        ST_RX: if (rx_done_i) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
        default:     state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign state_o = state_q;
  assign done_o  = done_q;

  a_r2_no_code_111: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != 3'b111);
  a_r3_hold_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ARM && !send_i && !abort_i) |=> state_q == ST_ARM);
  a_r4_field_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TX_GUARD && !field_ok_i) |=> state_q != ST_TX);
  a_r5_tx_min_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TX_GUARD && !tx_elapsed_i) |=> state_q != ST_TX);
  a_r7_rx_min_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RX_GUARD && (!rx_elapsed_i || !field_ok_i)) |=> state_q != ST_RX_WAIT);
  a_r8_done_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> ($past(state_q) == ST_RX && state_q == ST_IDLE));
  a_r10_abort_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (state_q == ST_IDLE && !done_q));
endmodule

// File: rtl/trx_sequencer.sv
module trx_sequencer
  import trx_seq_pkg::*;
#(
  parameter int WAIT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              abort_i,
  input  logic              start_i,
  input  logic              send_i,
  input  logic              field_i,
  input  logic              wait_field_en_i,
  input  logic [WAIT_W-1:0] tx_wait_i,
  input  logic [WAIT_W-1:0] rx_wait_i,
  input  logic              tx_done_i,
  input  logic              rx_detect_i,
  input  logic              rx_done_i,
  output logic [2:0]        state_o,
  output logic              tx_en_o,
  output logic              rx_en_o,
  output logic              done_o
);
  seq_state_e               state;
  logic                     field_ok;
  logic [N_GUARDS-1:0]      run;
  logic [N_GUARDS-1:0]      elapsed;
  logic [WAIT_W-1:0]        limit [N_GUARDS];

  assign field_ok    = !wait_field_en_i || field_i;
  assign run[G_TX]   = (state == ST_TX_GUARD);
  assign run[G_RX]   = (state == ST_RX_GUARD);
  assign limit[G_TX] = tx_wait_i;
  assign limit[G_RX] = rx_wait_i;

  for (genvar g = 0; g < N_GUARDS; g++) begin : g_guard
    trx_min_wait #(.CW(WAIT_W)) u_wait (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (run[g]),
      .limit_i   (limit[g]),
      .elapsed_o (elapsed[g])
    );
  end

  trx_seq_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .abort_i      (abort_i),
    .start_i      (start_i),
    .send_i       (send_i),
    .field_ok_i   (field_ok),
    .tx_elapsed_i (elapsed[G_TX]),
    .rx_elapsed_i (elapsed[G_RX]),
    .tx_done_i    (tx_done_i),
    .rx_detect_i  (rx_detect_i),
    .rx_done_i    (rx_done_i),
    .state_o      (state),
    .done_o       (done_o)
  );

  assign state_o = state;
  assign tx_en_o = (state == ST_TX);
  assign rx_en_o = (state == ST_RX_WAIT) || (state == ST_RX);

  a_r9_enables_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tx_en_o, rx_en_o}));
  a_r9_tx_after_guard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_en_o) |-> $past(state) == ST_TX_GUARD);
endmodule

// File: tb/trx_sequencer_tb_top.sv
`timescale 1ns/1ps
module trx_sequencer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic abort = 0, start = 0, send = 0, field = 0, wfe = 0;
  logic [7:0] txw = 0, rxw = 0;
  logic tx_done = 0, rx_det = 0, rx_done = 0;
  logic [2:0] state;
  logic tx_en, rx_en, done;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk; // 50 MHz

  trx_sequencer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .abort_i(abort), .start_i(start), .send_i(send),
    .field_i(field), .wait_field_en_i(wfe), .tx_wait_i(txw), .rx_wait_i(rxw),
    .tx_done_i(tx_done), .rx_detect_i(rx_det), .rx_done_i(rx_done),
    .state_o(state), .tx_en_o(tx_en), .rx_en_o(rx_en), .done_o(done)
  );

  // behavioural reference
  int ms = 0, mc = 0;
  bit md = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms <= 0; mc <= 0; md <= 0;
    end else begin
      int ns;
      bit nd;
      bit fok;
      ns = ms; nd = 0;
      fok = !wfe || field;
      if (abort) ns = 0;
      else case (ms)
        0: if (start) ns = 1;
        1: if (send) ns = 2;
        2: if (mc + 1 >= int'(txw) && fok) ns = 3;
        3: if (tx_done) ns = 4;
        4: if (mc + 1 >= int'(rxw) && fok) ns = 5;
        5: if (rx_det) ns = 6;
        6: if (rx_done) begin ns = 0; nd = 1; end
        default: ns = 0;
      endcase
      mc <= (ns == ms) ? mc + 1 : 0;
      ms <= ns;
      md <= nd;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string state_req(int s);
    case (s)
      0, 1: return "R3";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      default: return "R8";
    endcase
  endfunction

  // per-cycle compare against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(state != 3'b111, "R2", state, 0);
      chk(int'(state) == ms, state_req(ms), state, ms);
      chk(tx_en == (ms == 3), "R9", tx_en, ms == 3);
      chk(rx_en == (ms == 5 || ms == 6), "R9", rx_en, ms == 5 || ms == 6);
      chk(done == md, "R8", done, md);
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic quiet();
    abort = 0; start = 0; send = 0; tx_done = 0; rx_det = 0; rx_done = 0;
  endtask

  task automatic pulse_abort();
    abort = 1; tick(); abort = 0;
  endtask

  // from idle to the first cycle of 010
  task automatic to_tx_guard();
    start = 1; tick(); start = 0;
    send = 1; tick(); send = 0;
  endtask

  task automatic stay(input int code, output int n);
    n = 0;
    while (int'(state) == code && n < 600) begin n++; tick(); end
  endtask

  int n;

  initial begin
    repeat (3) tick();
    // R1 reset state
    chk(state == 3'b000, "R1", state, 0);
    chk(!tx_en && !rx_en && !done, "R1", {tx_en, rx_en, done}, 0);
    rst_n = 1;
    tick();

    // R3 armed state holds without send
    start = 1; tick(); start = 0;
    repeat (6) tick();
    chk(state == 3'b001, "R3", state, 1);
    send = 1; tick(); send = 0;
    chk(state == 3'b010, "R3", state, 2);
    pulse_abort(); tick();

    // R5 minimum wait lengths, field waiting off
    wfe = 0;
    for (int k = 0; k < 5; k++) begin
      int nv, expn;
      nv = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 2 : (k == 3) ? 7 : 40;
      expn = (nv == 0) ? 1 : nv;
      txw = 8'(nv);
      to_tx_guard();
      stay(2, n);
      chk(n == expn, "R5", n, expn);
      chk(state == 3'b011, "R5", state, 3);
      pulse_abort(); tick();
    end

    // R4 field gate, R11 stray flags in 010
    wfe = 1; field = 0; txw = 2;
    to_tx_guard();
    tx_done = 1; rx_done = 1; rx_det = 1;
    repeat (8) tick();
    quiet();
    chk(state == 3'b010, "R4", state, 2);
    chk(state == 3'b010, "R11", state, 2);
    field = 1; tick();
    chk(state == 3'b011, "R4", state, 3);
    // R6
    tx_done = 1; tick(); tx_done = 0;
    chk(state == 3'b100, "R6", state, 4);
    pulse_abort(); tick();

    // R4 field ignored when waiting is off
    wfe = 0; field = 0; txw = 1;
    to_tx_guard(); tick();
    chk(state == 3'b011, "R4", state, 3);

    // R7 receive guard uses its own minimum
    rxw = 5; txw = 30;
    tx_done = 1; tick(); tx_done = 0;
    stay(4, n);
    chk(n == 5, "R7", n, 5);
    chk(state == 3'b101 && rx_en, "R7", state, 5);
    // R11 rx_done ignored in 101
    rx_done = 1; tx_done = 1; tick(); rx_done = 0; tx_done = 0;
    chk(state == 3'b101, "R11", state, 5);
    // R8 detect, receive, done pulse
    rx_det = 1; tick(); rx_det = 0;
    chk(state == 3'b110, "R8", state, 6);
    rx_done = 1; tick(); rx_done = 0;
    chk(state == 3'b000 && done, "R8", {state, done}, 1);
    tick();
    chk(!done, "R8", done, 0);

    // R7 field gate on the receive guard
    wfe = 1; field = 1; txw = 0; rxw = 0;
    to_tx_guard(); tick();
    field = 0;
    tx_done = 1; tick(); tx_done = 0;
    repeat (5) tick();
    chk(state == 3'b100, "R7", state, 4);
    field = 1; tick();
    chk(state == 3'b101, "R7", state, 5);

    // R10 abort has priority and gives no done
    rx_det = 1; tick(); rx_det = 0;
    rx_done = 1; abort = 1; tick(); rx_done = 0; abort = 0;
    chk(state == 3'b000 && !done, "R10", {state, done}, 0);
    start = 1; abort = 1; tick(); start = 0; abort = 0;
    chk(state == 3'b000, "R10", state, 0);

    // random run, checked every cycle by the model
    for (int c = 0; c < 20000; c++) begin
      abort   = ($urandom % 64) == 0;
      start   = ($urandom % 4) == 0;
      send    = ($urandom % 4) == 0;
      tx_done = ($urandom % 5) == 0;
      rx_det  = ($urandom % 5) == 0;
      rx_done = ($urandom % 5) == 0;
      if (($urandom % 8) == 0) field = ~field;
      if (($urandom % 200) == 0) wfe = ~wfe;
      if (($urandom % 150) == 0) txw = 8'($urandom % 12);
      if (($urandom % 150) == 0) rxw = 8'($urandom % 12);
      tick();
    end
    quiet();
    tick();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    finished = 1;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule